// File: doc/BRIEF.md
# Multi-Channel SPI ADC Read Controller

This block is an SPI master that fetches one conversion result from an external successive-approximation converter. A client asks for a read by raising a start strobe while the block reports ready, together with a channel code and a flag that picks single-ended or differential input. The block selects the converter, sends a command byte that encodes the request, clocks in the response bytes and returns a right-justified sample with a one-cycle valid strobe.

A parameter sets the kind of converter attached: one with eight, four or two inputs, or one with a single input and no data-in pin. A second parameter sets the resolution to 10, 12 or 13 bits. Thirteen bits is defined only for the single-input kind, and that result is two's complement. Multi-input converters return their result at a different bit position than single-input ones. The block absorbs that difference, so the client always receives the sample in the low bits of a fixed-width word.

Top module: `spi_adc_reader`

## Requirements
- R1: After reset the chip select is high, the serial clock and serial data out are low, ready is high and valid is low.
- R2: A start strobe is taken only while ready is high, and the chip select goes low on the next cycle. A strobe that arrives during a transfer is ignored: that transfer still yields exactly one chip-select frame and exactly one result.
- R3: The serial clock idles low (SPI mode 0) and holds each level for CLK_DIV cycles. A frame has 24 rising edges on a multi-input converter (8 command bits and 16 response bits) and 16 on a single-input one. The input line is sampled at each rising edge.
- R4: With four or eight inputs, the command byte goes out MSB first. Bit 6 is 1, bit 5 is 1 for single-ended and 0 for differential, the channel code fills the bits from bit 2 upward, and every other bit is 0. In differential mode an even code makes the even input of the pair positive and an odd code makes it negative.
- R5: With two inputs, the command byte goes out MSB first. Bit 4 is 1, bit 3 is 1 for single-ended and 0 for differential, bit 2 holds the channel bit, and every other bit is 0.
- R6: A single-input converter gets no command. The data-out line stays low for the whole frame.
- R7: On a multi-input converter, data out is low during both response bytes. Whatever the converter returns while the command byte is shifting has no effect on the result.
- R8: Let byte0 be the first response byte. On a multi-input converter, a 10-bit sample is byte0 followed by bits 7:6 of byte1, and a 12-bit sample is byte0 followed by bits 7:4 of byte1. Both are zero-extended to SAMPLE_W.
- R9: On a single-input converter, a 10-bit sample is bits 4:0 of byte0 followed by bits 7:3 of byte1, and a 12-bit sample is bits 4:0 of byte0 followed by bits 7:1 of byte1. Both are zero-extended.
- R10: A 13-bit sample is bits 4:0 of byte0 followed by all of byte1, sign-extended from bit 12 to SAMPLE_W.
- R11: Valid is high for exactly one cycle, in the cycle where the chip select returns high. That cycle begins 2·N·CLK_DIV clock edges after the edge that took the start strobe, where N is the number of rising edges in the frame. Data holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Read request strobe |
| req_chan | input | CHAN_W | Channel code (ignored on single-input converters) |
| req_diff | input | 1 | 1 selects a differential pair, 0 single-ended |
| req_ready | output | 1 | High while a request can be taken |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | SAMPLE_W | Right-justified sample, sign-extended for 13 bits |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low converter select |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Response data from the converter |

## Verification
The bench runs five converter variants side by side. Each has its own model that changes the input line 1 ns after every falling serial-clock edge. The chip select falls one cycle after the accepting edge. The result strobe appears 2·N·CLK_DIV edges after that edge, and for CLK_DIV = 3 this is 144 cycles on a 24-edge frame and 96 on a 16-edge one. The bench samples at falling clock edges and records the cycle counter there. It then compares the distance from the request to the strobe with 2·N·CLK_DIV + 1. It counts rising-edge and chip-select events only once each frame has ended. It waits twelve more cycles before checking that the result is held and that no second frame has started.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Command length in bits: single-input converters receive nothing.
    function automatic int cmd_len(input int n_in);
        return (n_in > 1) ? 8 : 0;
    endfunction

    // Response length rounded up to whole bytes.
    function automatic int rx_len(input int res);
        return 8 * ((res + 7) / 8);
    endfunction

    // Right shift that brings the sample's LSB to bit 0 of the response word.
    function automatic int align_shift(input int n_in, input int res);
        if (n_in > 1) begin
            return rx_len(res) - res;
        end
        return 13 - res;
    endfunction

    function automatic bit is_signed(input int res);
        return res == 13;
    endfunction
endpackage

// File: rtl/spi_adc_cmd.sv
module spi_adc_cmd #(
    parameter int NUM_INPUTS = 8,
    parameter int CHAN_W     = 3
) (
    input  logic [CHAN_W-1:0] chan,
    input  logic              diff,
    output logic [7:0]        cmd
);
    timeunit 1ns;
    timeprecision 1ps;

    generate
        if (NUM_INPUTS >= 4) begin : g_wide
            // start at bit 6, single-ended flag at 5, channel from bit 2
            assign cmd = {1'b0, 1'b1, ~diff, 3'(chan), 2'b00};
        end else if (NUM_INPUTS == 2) begin : g_pair
            // start at bit 4, single-ended flag at 3, channel at bit 2
            assign cmd = {3'b000, 1'b1, ~diff, 1'(chan), 2'b00};
        end else begin : g_none
            assign cmd = 8'h00;
        end
    endgenerate
endmodule

// File: rtl/spi_adc_align.sv
module spi_adc_align #(
    parameter int RX_BITS    = 16,
    parameter int RES_BITS   = 12,
    parameter int SHIFT      = 4,
    parameter bit SIGNED_OUT = 1'b0,
    parameter int SAMPLE_W   = 16
) (
    input  logic [RX_BITS-1:0]  rx,
    output logic [SAMPLE_W-1:0] sample
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [SAMPLE_W-1:0] KEEP = SAMPLE_W'((64'd1 << RES_BITS) - 64'd1);

    logic [RX_BITS-1:0]  shifted;
    logic [SAMPLE_W-1:0] field;

    assign shifted = rx >> SHIFT;
    assign field   = SAMPLE_W'(shifted) & KEEP;

    generate
        if (SIGNED_OUT) begin : g_signed
            assign sample = field[RES_BITS-1] ? (field | ~KEEP) : field;
        end else begin : g_unsigned
            assign sample = field;
        end
    endgenerate
endmodule

// File: rtl/spi_adc_seq.sv
module spi_adc_seq #(
    parameter int CMD_BITS = 8,
    parameter int RX_BITS  = 16,
    parameter int CLK_DIV  = 2,
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [7:0]          cmd,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                miso,
    output logic                ready,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    output logic [RX_BITS-1:0]  rx_word,
    output logic                valid,
    output logic [SAMPLE_W-1:0] data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TOTAL = CMD_BITS + RX_BITS;
    localparam int BIT_W = $clog2(TOTAL);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] IDX_LAST = BIT_W'(TOTAL - 1);
    localparam logic [BIT_W-1:0] IDX_RX   = BIT_W'(CMD_BITS);

    typedef struct packed {
        logic                busy;
        logic                sclk;
        logic                cs_n;
        logic                mosi;
        logic                valid;
        logic [DIV_W-1:0]    div;
        logic [BIT_W-1:0]    idx;
        logic [6:0]          tx;
        logic [RX_BITS-1:0]  rx;
        logic [SAMPLE_W-1:0] data;
    } seq_t;

    localparam seq_t SEQ_RST = '{busy: 1'b0, sclk: 1'b0, cs_n: 1'b1, mosi: 1'b0,
                                 valid: 1'b0, div: '0, idx: '0, tx: '0, rx: '0,
                                 data: '0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy = 1'b1;
                seq_d.cs_n = 1'b0;
                seq_d.sclk = 1'b0;
                seq_d.div  = '0;
                seq_d.idx  = '0;
                seq_d.rx   = '0;
                seq_d.tx   = cmd[6:0];
                seq_d.mosi = (CMD_BITS > 0) ? cmd[7] : 1'b0;
            end
        end else if (seq_q.div != DIV_LAST) begin
            seq_d.div = seq_q.div + 1'b1;
        end else begin
            seq_d.div = '0;
            if (!seq_q.sclk) begin
                // rising edge: sample the converter during the response phase
                seq_d.sclk = 1'b1;
                if (seq_q.idx >= IDX_RX) begin
                    seq_d.rx = {seq_q.rx[RX_BITS-2:0], miso};
                end
            end else begin
                // falling edge: advance to the next bit or close the frame
                seq_d.sclk = 1'b0;
                if (seq_q.idx == IDX_LAST) begin
                    seq_d.busy  = 1'b0;
                    seq_d.cs_n  = 1'b1;
                    seq_d.mosi  = 1'b0;
                    seq_d.valid = 1'b1;
                    seq_d.data  = sample;
                end else begin
                    seq_d.idx  = seq_q.idx + 1'b1;
                    seq_d.tx   = {seq_q.tx[5:0], 1'b0};
                    seq_d.mosi = ((seq_q.idx + 1'b1) < IDX_RX) ? seq_q.tx[6] : 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready   = !seq_q.busy;
    assign sclk    = seq_q.sclk;
    assign cs_n    = seq_q.cs_n;
    assign mosi    = seq_q.mosi;
    assign rx_word = seq_q.rx;
    assign valid   = seq_q.valid;
    assign data    = seq_q.data;
endmodule

// File: rtl/spi_adc_reader.sv
module spi_adc_reader
    import spi_adc_pkg::*;
#(
    parameter int NUM_INPUTS = 8,
    parameter int RES_BITS   = 12,
    parameter int CLK_DIV    = 2,
    parameter int SAMPLE_W   = 16,
    localparam int CHAN_W    = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_start,
    input  logic [CHAN_W-1:0]   req_chan,
    input  logic                req_diff,
    output logic                req_ready,
    output logic                res_valid,
    output logic [SAMPLE_W-1:0] res_data,
    output logic                spi_sclk,
    output logic                spi_cs_n,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CMD_BITS   = cmd_len(NUM_INPUTS);
    localparam int RX_BITS    = rx_len(RES_BITS);
    localparam int SHIFT      = align_shift(NUM_INPUTS, RES_BITS);
    localparam bit SIGNED_OUT = is_signed(RES_BITS);

    logic [7:0]          cmd_byte;
    logic [RX_BITS-1:0]  rx_word;
    logic [SAMPLE_W-1:0] sample;

    spi_adc_cmd #(
        .NUM_INPUTS (NUM_INPUTS),
        .CHAN_W     (CHAN_W)
    ) u_cmd (
        .chan (req_chan),
        .diff (req_diff),
        .cmd  (cmd_byte)
    );

    spi_adc_align #(
        .RX_BITS    (RX_BITS),
        .RES_BITS   (RES_BITS),
        .SHIFT      (SHIFT),
        .SIGNED_OUT (SIGNED_OUT),
        .SAMPLE_W   (SAMPLE_W)
    ) u_align (
        .rx     (rx_word),
        .sample (sample)
    );

    spi_adc_seq #(
        .CMD_BITS (CMD_BITS),
        .RX_BITS  (RX_BITS),
        .CLK_DIV  (CLK_DIV),
        .SAMPLE_W (SAMPLE_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (req_start),
        .cmd     (cmd_byte),
        .sample  (sample),
        .miso    (spi_miso),
        .ready   (req_ready),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .rx_word (rx_word),
        .valid   (res_valid),
        .data    (res_data)
    );
endmodule

// File: rtl/spi_adc_reader_chk.sv
module spi_adc_reader_chk #(
    parameter int NUM_INPUTS = 8,
    parameter int RES_BITS   = 12,
    parameter int SAMPLE_W   = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_start,
    input logic                req_ready,
    input logic                res_valid,
    input logic [SAMPLE_W-1:0] res_data,
    input logic                spi_sclk,
    input logic                spi_cs_n,
    input logic                spi_mosi
);
    timeunit 1ns;
    timeprecision 1ps;

    a_r1_deselected_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);

    a_r2_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && req_ready) |=> !spi_cs_n);

    a_r3_clock_idles_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    a_r3_clock_moves_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_sclk) |-> !$past(spi_cs_n));

    a_r7_data_out_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_mosi);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r11_valid_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(spi_cs_n));

    generate
        if (NUM_INPUTS == 1) begin : g_rx_only
            a_r6_no_command: assert property (@(posedge clk) disable iff (!rst_n)
                !spi_mosi);
        end
        if (RES_BITS == 13) begin : g_sext
            a_r10_sign_extended: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid |-> (($countones(res_data[SAMPLE_W-1:RES_BITS-1]) == 0) ||
                               ($countones(res_data[SAMPLE_W-1:RES_BITS-1]) == SAMPLE_W - RES_BITS + 1)));
        end else begin : g_zext
            a_r8_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid |-> (res_data[SAMPLE_W-1:RES_BITS] == '0));
        end
    endgenerate
endmodule

bind spi_adc_reader spi_adc_reader_chk #(
    .NUM_INPUTS (NUM_INPUTS),
    .RES_BITS   (RES_BITS),
    .SAMPLE_W   (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi)
);

// File: tb/test_spi_adc_reader.sv
module test_spi_adc_reader;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NDUT = 5;
    localparam int DIV  = 3;
    localparam int NI_TAB [NDUT] = '{8, 2, 1, 1, 1};
    localparam int RB_TAB [NDUT] = '{12, 10, 10, 12, 13};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic        start_s [NDUT];
    logic [2:0]  chan_s  [NDUT];
    logic        diff_s  [NDUT];
    logic        ready_s [NDUT];
    logic        valid_s [NDUT];
    logic [15:0] data_s  [NDUT];
    logic        sclk_s  [NDUT];
    logic        cs_s    [NDUT];
    logic        mosi_s  [NDUT];
    logic        miso_s  [NDUT];
    logic [23:0] pat     [NDUT];
    logic [23:0] seen    [NDUT];
    int          edges   [NDUT] = '{default: 0};
    int          falls   [NDUT] = '{default: 0};
    int          got_n   [NDUT] = '{default: 0};
    int          got_cyc [NDUT] = '{default: 0};
    logic [15:0] got_data[NDUT];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    generate
        for (genvar k = 0; k < NDUT; k++) begin : g_dut
            localparam int NI = NI_TAB[k];
            localparam int RB = RB_TAB[k];
            localparam int CW = (NI > 1) ? $clog2(NI) : 1;
            localparam int NB = (NI > 1) ? 24 : 16;

            spi_adc_reader #(
                .NUM_INPUTS (NI),
                .RES_BITS   (RB),
                .CLK_DIV    (DIV),
                .SAMPLE_W   (16)
            ) i_spi_adc_reader (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_start (start_s[k]),
                .req_chan  (chan_s[k][CW-1:0]),
                .req_diff  (diff_s[k]),
                .req_ready (ready_s[k]),
                .res_valid (valid_s[k]),
                .res_data  (data_s[k]),
                .spi_sclk  (sclk_s[k]),
                .spi_cs_n  (cs_s[k]),
                .spi_mosi  (mosi_s[k]),
                .spi_miso  (miso_s[k])
            );

            // converter model: new bit shortly after each falling SCLK edge
            initial begin
                miso_s[k] = 1'b0;
                forever begin
                    @(negedge cs_s[k]);
                    for (int i = 0; i < NB; i++) begin
                        if (i != 0) @(negedge sclk_s[k]);
                        #1 miso_s[k] = pat[k][NB-1-i];
                    end
                end
            end

            always @(posedge sclk_s[k]) begin
                edges[k] <= edges[k] + 1;
                seen[k]  <= {seen[k][22:0], mosi_s[k]};
            end

            always @(negedge cs_s[k]) falls[k] <= falls[k] + 1;

            always @(negedge clk) begin
                if (valid_s[k] === 1'b1) begin
                    got_n[k]    <= got_n[k] + 1;
                    got_cyc[k]  <= cyc;
                    got_data[k] <= data_s[k];
                end
            end
        end
    endgenerate

    task automatic chk(input bit ok, input string req, input int k,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s inst %0d actual %h expected %h", req, k, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input int ni, input logic [2:0] ch, input logic df);
        logic [7:0] c;
        if (ni >= 4) c = 8'h40 | (df ? 8'h00 : 8'h20) | {3'b000, ch & 3'(ni - 1), 2'b00};
        else         c = 8'h10 | (df ? 8'h00 : 8'h08) | {5'b00000, ch[0], 2'b00};
        return c;
    endfunction

    function automatic logic [15:0] exp_sample(input int ni, input int res,
                                               input logic [7:0] b0, input logic [7:0] b1);
        if (ni > 1) begin
            if (res == 10) return {6'd0, b0, b1[7:6]};
            return {4'd0, b0, b1[7:4]};
        end
        if (res == 10) return {6'd0, b0[4:0], b1[7:3]};
        if (res == 12) return {4'd0, b0[4:0], b1[7:1]};
        return {{3{b0[4]}}, b0[4:0], b1};
    endfunction

    task automatic run_read(input logic [2:0] ch, input logic df, input logic [7:0] b0,
                            input logic [7:0] b1, input logic [7:0] junk, input bit poke);
        int n0 [NDUT];
        int e0 [NDUT];
        int f0 [NDUT];
        int t0;
        bit all;
        for (int k = 0; k < NDUT; k++) begin
            n0[k] = got_n[k];
            e0[k] = edges[k];
            f0[k] = falls[k];
            pat[k]    = (NI_TAB[k] > 1) ? {junk, b0, b1} : {8'h00, b0, b1};
            chan_s[k] = ch;
            diff_s[k] = df;
        end
        @(negedge clk);
        t0 = cyc;
        for (int k = 0; k < NDUT; k++) start_s[k] = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NDUT; k++) start_s[k] = 1'b0;
        if (poke) begin
            // R2: strobe while every instance is mid-frame
            repeat (20) @(negedge clk);
            for (int k = 0; k < NDUT; k++) begin
                start_s[k] = 1'b1;
                chan_s[k]  = ~ch;
            end
            @(negedge clk);
            for (int k = 0; k < NDUT; k++) start_s[k] = 1'b0;
        end
        forever begin
            @(negedge clk);
            all = 1'b1;
            for (int k = 0; k < NDUT; k++) if (got_n[k] == n0[k]) all = 1'b0;
            if (all) break;
        end
        repeat (12) @(negedge clk);
        for (int k = 0; k < NDUT; k++) begin
            int nb;
            string dreq;
            nb   = (NI_TAB[k] > 1) ? 24 : 16;
            dreq = (NI_TAB[k] > 1) ? "R8" : ((RB_TAB[k] == 13) ? "R10" : "R9");
            chk(got_data[k] == exp_sample(NI_TAB[k], RB_TAB[k], b0, b1), dreq, k,
                32'(got_data[k]), 32'(exp_sample(NI_TAB[k], RB_TAB[k], b0, b1)));
            chk(got_cyc[k] - t0 == 2 * nb * DIV + 1, "R11 latency", k,
                32'(got_cyc[k] - t0), 32'(2 * nb * DIV + 1));
            chk(data_s[k] == got_data[k], "R11 hold", k, 32'(data_s[k]), 32'(got_data[k]));
            chk(edges[k] - e0[k] == nb, "R3 edges", k, 32'(edges[k] - e0[k]), 32'(nb));
            chk((falls[k] - f0[k] == 1) && (got_n[k] - n0[k] == 1), "R2 one frame", k,
                32'(falls[k] - f0[k]), 32'd1);
            chk(seen[k][15:0] == 16'h0000, (NI_TAB[k] > 1) ? "R7 quiet" : "R6 quiet", k,
                32'(seen[k][15:0]), 32'h0);
            if (NI_TAB[k] > 1) begin
                chk(seen[k][23:16] == exp_cmd(NI_TAB[k], ch, df),
                    (NI_TAB[k] >= 4) ? "R4 cmd" : "R5 cmd", k,
                    32'(seen[k][23:16]), 32'(exp_cmd(NI_TAB[k], ch, df)));
            end
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h0005_EED5);
        for (int k = 0; k < NDUT; k++) begin
            start_s[k] = 1'b0;
            chan_s[k]  = 3'd0;
            diff_s[k]  = 1'b0;
            pat[k]     = 24'h0;
        end
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NDUT; k++) begin
            chk(cs_s[k] === 1'b1 && sclk_s[k] === 1'b0 && mosi_s[k] === 1'b0,
                "R1 pins", k, {29'd0, cs_s[k], sclk_s[k], mosi_s[k]}, 32'h4);
            chk(ready_s[k] === 1'b1 && valid_s[k] === 1'b0, "R1 handshake", k,
                {30'd0, ready_s[k], valid_s[k]}, 32'h2);
        end
        // directed corners: all ones, all zeros, 13-bit extremes, pattern, strobe while busy
        run_read(3'd0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0);
        run_read(3'd7, 1'b1, 8'h00, 8'h00, 8'hFF, 1'b0);
        run_read(3'd7, 1'b0, 8'h10, 8'h00, 8'h5A, 1'b0);
        run_read(3'd3, 1'b1, 8'h0F, 8'hFF, 8'h00, 1'b0);
        run_read(3'd5, 1'b1, 8'hA5, 8'h5A, 8'hC3, 1'b1);
        run_read(3'd6, 1'b0, 8'hE0, 8'h1F, 8'h81, 1'b1);
        for (int n = 0; n < 30; n++) begin
            run_read(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                     8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom_range(0, 3) == 0));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule